// File: doc/BRIEF.md
# Card socket status-change interrupt unit

This block watches the signals of one removable-card socket: two card-detect pins, two battery-voltage detects, ready/busy, write protect, wait and power-on, plus a single-cycle access-timeout pulse from the access engine. Every transition of a watched signal latches a sticky change flag. Software enables the flags it cares about; their combined request forms a status-change interrupt. A control bit steers that interrupt to one of two host interrupt lines. The card's own I/O interrupt request has a separate enable and a separate steering bit.

Software uses a small register port with three words. Control word A holds the mode, enable and steering bits. Control word B holds a diagnostic mode, which replaces the card pins with register bits. The status word shows the live levels, the change flags and the two posted-interrupt bits. A memory-only socket and a memory-plus-I/O socket show different signals in four of the status bits.

Top module: `card_sc_irq`

## Requirements
- R1: After reset both control words and the status word read 0x0000 (with all inputs low), and host_irq is 2'b00.
- R2: In memory mode, status bits 7:0 show the synchronized pin levels after two clock edges: bit 0 power-on, 1 wait, 2 write protect, 3 ready, 4 battery 1, 5 battery 2, 6 card-detect 1, 7 card-detect 2.
- R3: Either edge of a watched level sets its sticky flag one edge after the status bit changes: bit 9 write protect, 10 ready, 11 battery 1, 12 battery 2, 13 either card-detect pin. Power-on and wait set no flag.
- R4: A high timeout pulse on a clock edge sets status bit 8.
- R5: Writing the status word (select 2) clears each flag in bits 13:8 whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R6: When a flag's set condition and its clear write fall on the same edge, the flag ends set.
- R7: Control word A bits 13:8 enable the flags in the same positions. The status-change interrupt is the OR of enabled flags, is shown in status bit 14, and stays high until the flags are cleared.
- R8: Control word A bit 3 steers the status-change interrupt to host_irq[0] when 0 and to host_irq[1] when 1.
- R9: The I/O interrupt (request input io_in[1]) reaches a host line only when control word A bit 0 (I/O mode) and bit 1 (enable) are both set. Bit 2 steers it to line 0 or line 1. Status bit 15 shows the request in I/O mode and reads 0 in memory mode.
- R10: In I/O mode, status bits 5:2 show io_in[3:0] (IOIS16, request, status-change, speaker) instead of the memory-mode signals.
- R11: With control word B bit 0 set, bits 1 to 6 (wait, write protect, ready, battery 1, battery 2, card detect) replace the matching pins. The card-detect bit drives both detect positions, and the substituted levels feed the change flags.
- R12: Control word A reads back only bits 13:8 and 3:0, and control word B only bits 6:0; all other bits read 0. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| card_in | input | 8 | Raw card pins in status-bit order |
| io_in | input | 4 | Raw I/O-mode signals: IOIS16, request, status-change, speaker |
| tmo_pulse | input | 1 | Synchronous access-timeout pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Word select: 0 control A, 1 control B, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected word |
| host_irq | output | 2 | Two host interrupt lines |

## Verification
The assertions assume that the timeout pulse comes from the same clock domain and that reg_sel and the write strobe are never unknown after reset. The card pins may be asynchronous, and the synchronizer absorbs them. The stimulus changes every input only at the falling clock edge and holds each pin pattern for several cycles, so each transition is seen exactly once. Same-edge collisions between a set and a clear are created on purpose, with the pulse and the write placed in the same cycle.

// File: rtl/card_sc_irq.sv
module card_sc_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  card_in,
  input  logic [3:0]  io_in,
  input  logic        tmo_pulse,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic [1:0]  host_irq
);
  localparam int NPIN = 12;
  localparam int NSRC = 6;

  logic [NPIN-1:0] sync_q [SYNC_STAGES];
  logic [7:0]      prev_q;
  logic [NSRC-1:0] chg_q, en_q, dg_q;
  logic            io_mode, io_ie, io_line, sc_line, diag_en;

  wire [NPIN-1:0] pin_s = sync_q[SYNC_STAGES-1];
  wire wr_a    = reg_wr && reg_sel == 2'd0;
  wire wr_b    = reg_wr && reg_sel == 2'd1;
  wire wr_stat = reg_wr && reg_sel == 2'd2;
  wire unused_wdata = &{1'b0, reg_wdata[15:14], reg_wdata[7:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {io_in, card_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  logic [7:0] card_eff;
  assign card_eff = diag_en ? {dg_q[5], dg_q[5], dg_q[4], dg_q[3], dg_q[2], dg_q[1], dg_q[0], pin_s[0]}
                            : pin_s[7:0];

  wire [7:0]      diff    = card_eff ^ prev_q;
  wire [NSRC-1:0] set_chg = {diff[7] | diff[6], diff[5], diff[4], diff[3], diff[2], tmo_pulse};
  wire [NSRC-1:0] clr_chg = wr_stat ? reg_wdata[13:8] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      chg_q   <= '0;
      en_q    <= '0;
      dg_q    <= '0;
      io_mode <= 1'b0;
      io_ie   <= 1'b0;
      io_line <= 1'b0;
      sc_line <= 1'b0;
      diag_en <= 1'b0;
    end else begin
      prev_q <= card_eff;
      chg_q  <= (chg_q & ~clr_chg) | set_chg;
      if (wr_a) begin
        en_q    <= reg_wdata[13:8];
        sc_line <= reg_wdata[3];
        io_line <= reg_wdata[2];
        io_ie   <= reg_wdata[1];
        io_mode <= reg_wdata[0];
      end
      if (wr_b) begin
        dg_q    <= reg_wdata[6:1];
        diag_en <= reg_wdata[0];
      end
    end
  end

  wire sc_irq = |(chg_q & en_q);
  wire io_req = io_mode && pin_s[9];
  wire io_irq = io_req && io_ie;

  assign host_irq[0] = (sc_irq && !sc_line) || (io_irq && !io_line);
  assign host_irq[1] = (sc_irq &&  sc_line) || (io_irq &&  io_line);

  wire [7:0]  live   = io_mode ? {card_eff[7:6], pin_s[11:8], card_eff[1:0]} : card_eff;
  wire [15:0] status = {io_req, sc_irq, chg_q, live};

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {2'b00, en_q, 4'b0000, sc_line, io_line, io_ie, io_mode};
      2'd1:    reg_rdata = {9'd0, dg_q, diag_en};
      2'd2:    reg_rdata = status;
      default: reg_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/card_sc_irq_chk.sv
module card_sc_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        tmo_pulse,
  input logic [1:0]  host_irq,
  input logic [5:0]  chg_q,
  input logic        io_mode,
  input logic        io_ie
);
  wire stat_wr = reg_wr && reg_sel == 2'd2;

  a_r4_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> chg_q[0]);

  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[8] && !tmo_pulse) |=> !chg_q[0]);

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((chg_q & $past(chg_q)) == $past(chg_q)));

  a_r7_no_irq_without_source: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q == 6'd0 && !(io_mode && io_ie)) |-> host_irq == 2'b00);

  a_r9_io_bit_memory_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2 && !io_mode) |-> !reg_rdata[15]);
endmodule

bind card_sc_irq card_sc_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmo_pulse(tmo_pulse),
  .host_irq(host_irq), .chg_q(chg_q), .io_mode(io_mode), .io_ie(io_ie)
);

// File: tb/card_sc_irq_bench.sv
module card_sc_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  card_in = '0;
  logic [3:0]  io_in = '0;
  logic        tmo_pulse = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  host_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  card_sc_irq u_card_sc_irq (.*);

  // {card pins, expected status} in memory mode, flags cleared after each step
  localparam logic [23:0] VEC [11] = '{
    {8'h01, 16'h0001}, {8'h03, 16'h0003}, {8'h07, 16'h0207}, {8'h0F, 16'h040F},
    {8'h1F, 16'h081F}, {8'h3F, 16'h103F}, {8'h7F, 16'h207F}, {8'hFF, 16'h20FF},
    {8'h00, 16'h3E00}, {8'h24, 16'h1224}, {8'h80, 16'h3280}};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [15:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 ctrl A", v, 16'h0000);
    rd(2'd1, v); check("R1 ctrl B", v, 16'h0000);
    rd(2'd2, v); check("R1 status", v, 16'h0000);
    check("R1 host_irq", {14'd0, host_irq}, 16'h0000);

    for (int i = 0; i < 11; i++) begin
      @(negedge clk); card_in = VEC[i][23:16];
      settle();
      rd(2'd2, v); check("R2/R3 pin vector", v, VEC[i][15:0]);
      wr(2'd2, 16'h3F00);
    end
    @(negedge clk); card_in = 8'h00; settle(); wr(2'd2, 16'h3F00);

    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R12 ctrl A readback", v, 16'h3F0F);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFE); rd(2'd1, v); check("R12 ctrl B readback", v, 16'h007E);
    wr(2'd1, 16'h0000);
    rd(2'd3, v); check("R12 unused select", v, 16'h0000);

    @(negedge clk); tmo_pulse = 1'b1; @(negedge clk); tmo_pulse = 1'b0;
    rd(2'd2, v); check("R4 timeout flag", v, 16'h0100);
    wr(2'd0, 16'h0200);
    check("R7 masked flag gives no irq", {14'd0, host_irq}, 16'h0000);
    wr(2'd0, 16'h0100);
    check("R7 enabled flag on line 0", {14'd0, host_irq}, 16'h0001);
    rd(2'd2, v); check("R7 posted bit 14", v, 16'h4100);
    wr(2'd2, 16'h0000);
    rd(2'd2, v); check("R5 zero write keeps flag", v, 16'h4100);
    wr(2'd0, 16'h0108);
    check("R8 steered to line 1", {14'd0, host_irq}, 16'h0002);
    @(negedge clk); reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 16'h0100; tmo_pulse = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tmo_pulse = 1'b0;
    rd(2'd2, v); check("R6 set wins over clear", v, 16'h4100);
    wr(2'd2, 16'h0100);
    rd(2'd2, v); check("R5 one write clears", v, 16'h0000);
    check("R7 irq drops after clear", {14'd0, host_irq}, 16'h0000);

    wr(2'd0, 16'h0003);
    @(negedge clk); io_in = 4'b1010; settle();
    check("R9 io irq line 0", {14'd0, host_irq}, 16'h0001);
    rd(2'd2, v); check("R10 io-mode status bits", v, 16'h8028);
    wr(2'd0, 16'h0007);
    check("R9 io irq line 1", {14'd0, host_irq}, 16'h0002);
    wr(2'd0, 16'h0001);
    check("R9 io enable off", {14'd0, host_irq}, 16'h0000);
    wr(2'd0, 16'h0002);
    check("R9 memory mode blocks io", {14'd0, host_irq}, 16'h0000);
    rd(2'd2, v); check("R9 bit 15 zero in memory mode", v, 16'h0000);
    wr(2'd0, 16'h0000);
    @(negedge clk); io_in = 4'b0000; settle();

    @(negedge clk); card_in = 8'h01; settle(); wr(2'd2, 16'h3F00);
    wr(2'd1, 16'h0045); settle();
    rd(2'd2, v); check("R11 diagnostic substitution", v, 16'h22C5);
    wr(2'd2, 16'h3F00);
    wr(2'd1, 16'h0000); settle();
    rd(2'd2, v); check("R11 leaving diagnostic mode", v, 16'h2201);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule